// File: doc/BRIEF.md
# Sample Decimator and Averager

This block lowers the rate of a free-running stream of signed 14-bit converter samples. Four channels arrive on every clock. Two of them are used by default, and all four are used in quad mode. A programmable group size sets how many raw samples are combined into one result. In pick mode the result is the first raw sample of the group. In sum mode it is the signed sum of every raw sample in the group.

Each channel result is arithmetically shifted right by a programmable count and sign-extended into a 32-bit half of a 64-bit output word. Words leave on a single-cycle strobe, `word_valid_o`, with no ready signal. The source is a converter that cannot pause, so there is no back-pressure path: a consumer must accept every strobed word in the cycle it appears. In quad mode two words are strobed per group, on consecutive clocks.

A `start_i` pulse places the current sample at the head of a new group. After that, groups follow back to back without further pulses. Dropping `run_i` halts everything at once. Triggering, record counting and buffering are the job of neighbouring blocks.

Top module: `sample_decimator`

## Requirements
- R1: After reset, `word_valid_o` is 0 and `word_o` is all zeros until the first group completes.
- R2: A group holds `factor_i + 1` raw samples. Its first output word is strobed in the clock cycle after the group's last raw sample is presented.
- R3: With `avg_en_i` low, the result of a channel is the first raw sample of the group.
- R4: With `avg_en_i` high, the result of a channel is the signed sum of all raw samples in the group, with no wrap for any 18-bit group size.
- R5: Each result is arithmetically shifted right by `shift_i` (0 to 15) and sign-extended to 32 bits. Channel 0 occupies word bits 31:0 and channel 1 occupies bits 63:32.
- R6: With `quad_en_i` low, exactly one word is strobed per group.
- R7: With `quad_en_i` high, two words are strobed on consecutive clocks. The first holds channels 0 and 1. The second holds channel 2 in bits 31:0 and channel 3 in bits 63:32. Quad mode requires `factor_i` to be at least 1.
- R8: While `run_i` is low, no word is strobed from the next clock on, and the group position and sums are cleared. A pending second word is dropped. After `run_i` returns, no group begins until `start_i` is pulsed.
- R9: A `start_i` pulse in the middle of a group abandons the partial group. The sample presented with the pulse becomes the first sample of a fresh group.
- R10: Once started, groups follow each other back to back without further `start_i` pulses.
- R11: With `factor_i` equal to 0, every raw sample produces a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enables processing; low clears and silences the block |
| start_i | input | 1 | Marks the current sample as the head of a group |
| avg_en_i | input | 1 | 1 = sum the group, 0 = pick the first sample |
| quad_en_i | input | 1 | 1 = four channels, two words per group |
| factor_i | input | 18 | Group size minus one |
| shift_i | input | 4 | Right-shift applied to each result |
| adc_i | input | 56 | Four packed 14-bit samples, channel 0 in bits 13:0 |
| word_o | output | 64 | Packed pair of 32-bit channel results |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
A table of configurations is driven with a deterministic stream of mixed positive and negative samples. Pick and sum mode are run with the same group size, so a dropped or extra sample in the sum shows up as a mismatch. Nonzero shifts on negative sums tell an arithmetic shift from a logical one. A large group shows whether the accumulator holds full width. Quad cases check the channel order and the spacing of the second word. A group size of one shows whether the group counter handles its boundary at zero. Directed sequences then drop `run_i` mid-group and re-pulse `start_i` mid-group, and count the words that emerge.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int ADC_W_DEF   = 14;
  localparam int FACT_W_DEF  = 18;
  localparam int SHIFT_W_DEF = 4;
  localparam int HALF_W_DEF  = 32;
  localparam int NUM_CH      = 4;
endpackage

// File: rtl/dec_group_ctrl.sv
module dec_group_ctrl #(
  parameter int FACT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              start_i,
  input  logic [FACT_W-1:0] factor_i,
  output logic              take_o,
  output logic              first_o,
  output logic              last_o
);
  logic [FACT_W-1:0] cnt_q;
  logic [FACT_W-1:0] pos;
  logic              active_q;

  assign take_o  = run_i & (start_i | active_q);
  assign pos     = start_i ? '0 : cnt_q;
  assign first_o = take_o & (pos == '0);
  assign last_o  = take_o & (pos == factor_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (take_o) begin
      active_q <= 1'b1;
      cnt_q    <= last_o ? '0 : pos + FACT_W'(1);
    end
  end
endmodule

// File: rtl/dec_chan_acc.sv
module dec_chan_acc #(
  parameter int ADC_W   = 14,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 4,
  parameter int HALF_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               take_i,
  input  logic               first_i,
  input  logic               avg_i,
  input  logic [ADC_W-1:0]   sample_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [HALF_W-1:0]  result_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] samp_ext;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] shifted;

  assign samp_ext = {{(ACC_W-ADC_W){sample_i[ADC_W-1]}}, sample_i};

  always_comb begin
    if (first_i)    acc_nxt = samp_ext;
    else if (avg_i) acc_nxt = acc_q + samp_ext;
    else            acc_nxt = acc_q;
  end

  assign shifted = acc_nxt >>> shift_i;

  generate
    if (HALF_W > ACC_W) begin : g_ext
      assign result_o = {{(HALF_W-ACC_W){shifted[ACC_W-1]}}, shifted};
    end else begin : g_trunc
      assign result_o = shifted[HALF_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (!run_i)  acc_q <= '0;
    else if (take_i)  acc_q <= acc_nxt;
  end
endmodule

// File: rtl/dec_packer.sv
module dec_packer #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                last_i,
  input  logic                quad_i,
  input  logic [4*HALF_W-1:0] res_i,
  output logic [2*HALF_W-1:0] word_o,
  output logic                valid_o
);
  logic [2*HALF_W-1:0] hold_q;
  logic                pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
    end else if (!run_i) begin
      valid_o <= 1'b0;
      pend_q  <= 1'b0;
    end else if (last_i) begin
      word_o  <= res_i[2*HALF_W-1:0];
      valid_o <= 1'b1;
      hold_q  <= res_i[4*HALF_W-1:2*HALF_W];
      pend_q  <= quad_i;
    end else if (pend_q) begin
      word_o  <= hold_q;
      valid_o <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_decimator.sv
module sample_decimator
  import dec_pkg::*;
#(
  parameter int ADC_W   = ADC_W_DEF,
  parameter int FACT_W  = FACT_W_DEF,
  parameter int SHIFT_W = SHIFT_W_DEF,
  parameter int HALF_W  = HALF_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    start_i,
  input  logic                    avg_en_i,
  input  logic                    quad_en_i,
  input  logic [FACT_W-1:0]       factor_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic [NUM_CH*ADC_W-1:0] adc_i,
  output logic [2*HALF_W-1:0]     word_o,
  output logic                    word_valid_o
);
  localparam int ACC_W = ADC_W + FACT_W;

  logic grp_take;
  logic grp_first;
  logic grp_last;
  logic [NUM_CH*HALF_W-1:0] results;

  dec_group_ctrl #(.FACT_W(FACT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .start_i  (start_i),
    .factor_i (factor_i),
    .take_o   (grp_take),
    .first_o  (grp_first),
    .last_o   (grp_last)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      dec_chan_acc #(
        .ADC_W   (ADC_W),
        .ACC_W   (ACC_W),
        .SHIFT_W (SHIFT_W),
        .HALF_W  (HALF_W)
      ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .take_i   (grp_take),
        .first_i  (grp_first),
        .avg_i    (avg_en_i),
        .sample_i (adc_i[ch*ADC_W +: ADC_W]),
        .shift_i  (shift_i),
        .result_o (results[ch*HALF_W +: HALF_W])
      );
    end
  endgenerate

  dec_packer #(.HALF_W(HALF_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .last_i  (grp_last),
    .quad_i  (quad_en_i),
    .res_i   (results),
    .word_o  (word_o),
    .valid_o (word_valid_o)
  );
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int FACT_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic              quad_en_i,
  input logic [FACT_W-1:0] factor_i,
  input logic              grp_last,
  input logic              word_valid_o
);
  p_halt_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !word_valid_o);

  p_group_end_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && grp_last) |=> word_valid_o);

  p_second_word_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grp_last && quad_en_i && run_i) && run_i) |=> word_valid_o);

  p_single_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !quad_en_i && $past(!quad_en_i) && (factor_i != '0)
     && $stable(factor_i)) |=> !word_valid_o);
endmodule

bind sample_decimator dec_checker #(.FACT_W(FACT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_i        (run_i),
  .quad_en_i    (quad_en_i),
  .factor_i     (factor_i),
  .grp_last     (grp_last),
  .word_valid_o (word_valid_o)
);

// File: tb/sample_decimator_test.sv
module sample_decimator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // columns: avg, factor, shift, quad
  localparam int VEC [NV][4] = '{
    '{0, 0,   0,  0},
    '{0, 3,   0,  0},
    '{1, 3,   0,  0},
    '{1, 4,   2,  0},
    '{1, 1,   0,  1},
    '{0, 2,   1,  1},
    '{1, 999, 10, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        start_i = 1'b0;
  logic        avg_en_i = 1'b0;
  logic        quad_en_i = 1'b0;
  logic [17:0] factor_i = '0;
  logic [3:0]  shift_i = '0;
  logic [55:0] adc_i = '0;
  logic [63:0] word_o;
  logic        word_valid_o;

  int checks = 0;
  int fails  = 0;
  int base   = 0;
  int ncap   = 0;
  logic [63:0] cap [16];

  sample_decimator uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start_i),
    .avg_en_i(avg_en_i), .quad_en_i(quad_en_i), .factor_i(factor_i),
    .shift_i(shift_i), .adc_i(adc_i), .word_o(word_o),
    .word_valid_o(word_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (word_valid_o) begin
      if (ncap < 16) cap[ncap] = word_o;
      ncap = ncap + 1;
    end
  end

  function automatic logic signed [13:0] samp(int i, int ch);
    int v;
    v = (i * 1237 + ch * 3001 + 77) % 16384;
    return v[13:0];
  endfunction

  function automatic logic [31:0] exp_half(int b, int fac, int avg, int sh, int ch);
    longint s;
    s = 0;
    if (avg != 0) begin
      for (int k = 0; k <= fac; k++) s = s + longint'(samp(b + k, ch));
    end else begin
      s = longint'(samp(b, ch));
    end
    s = s >>> sh;
    return s[31:0];
  endfunction

  task automatic put_samples(int i);
    for (int ch = 0; ch < 4; ch++) adc_i[ch*14 +: 14] = samp(i, ch);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feed(int n, bit st);
    for (int i = 0; i < n; i++) begin
      start_i = st && (i == 0);
      put_samples(base + i);
      @(negedge clk);
    end
    start_i = 1'b0;
    base = base + n;
  endtask

  task automatic configure(int avg, int fac, int sh, int quad);
    @(negedge clk);
    run_i = 1'b0; start_i = 1'b0;
    avg_en_i = avg[0]; factor_i = 18'(fac); shift_i = 4'(sh); quad_en_i = quad[0];
    @(negedge clk);
    ncap = 0;
    run_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(word_valid_o), 64'd0);
    check("R1 word after reset", word_o, 64'd0);

    // table-driven main function
    for (int v = 0; v < NV; v++) begin
      int avg, fac, sh, quad, ng, b0, per;
      string tag;
      avg = VEC[v][0]; fac = VEC[v][1]; sh = VEC[v][2]; quad = VEC[v][3];
      ng  = (fac > 100) ? 1 : 3;
      per = (quad != 0) ? 2 : 1;
      if (fac == 0)       tag = "R11";
      else if (quad != 0) tag = "R7";
      else if (sh != 0)   tag = "R5";
      else if (avg != 0)  tag = "R4";
      else                tag = "R3";
      configure(avg, fac, sh, quad);
      b0 = base;
      feed(ng * (fac + 1), 1'b1);
      check("R2 strobe after last sample", 64'(word_valid_o), 64'd1);
      if (quad != 0) @(negedge clk);
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      if (quad != 0) check("R7 word count", 64'(ncap), 64'(ng * per));
      else           check("R6 word count R10", 64'(ncap), 64'(ng * per));
      for (int g = 0; g < ng && g * per < 16; g++) begin
        int gb;
        gb = b0 + g * (fac + 1);
        check(tag, cap[g*per], {exp_half(gb, fac, avg, sh, 1), exp_half(gb, fac, avg, sh, 0)});
        if (quad != 0)
          check("R7 second word", cap[g*per+1],
                {exp_half(gb, fac, avg, sh, 3), exp_half(gb, fac, avg, sh, 2)});
      end
    end

    // R8: halt mid-group, resume without start
    configure(1, 3, 0, 0);
    feed(2, 1'b1);
    run_i = 1'b0;
    @(negedge clk);
    run_i = 1'b1;
    feed(8, 1'b0);
    check("R8 no word without start", 64'(ncap), 64'd0);
    begin
      int b0;
      b0 = base;
      feed(4, 1'b1);
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 word count after restart", 64'(ncap), 64'd1);
      check("R8 sum after restart", cap[0], {exp_half(b0, 3, 1, 0, 1), exp_half(b0, 3, 1, 0, 0)});
    end

    // R8: halt drops a pending second word
    configure(0, 1, 0, 1);
    feed(2, 1'b1);
    run_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pending word dropped", 64'(ncap), 64'd1);

    // R9: restart inside a group
    configure(1, 3, 1, 0);
    feed(2, 1'b1);
    begin
      int b0;
      b0 = base;
      feed(4, 1'b1);
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 word count", 64'(ncap), 64'd1);
      check("R9 restarted sum", cap[0], {exp_half(b0, 3, 1, 1, 1), exp_half(b0, 3, 1, 1, 0)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule